// File: doc/BRIEF.md
# MDIO Station Management Controller

This block runs clause-22 management frames to an external PHY over a two-wire management bus (a clock output and a bidirectional data line). A host loads the 16-bit value to send into a write-data register, then writes a command word. The command word holds a write-request bit, a read-request bit, a 5-bit PHY address and a 5-bit register number. Writing the command starts the frame. The request bit stays set while the frame is on the wire, and hardware clears it when the frame ends. Software polls that bit to learn when the transaction is complete.

The bidirectional data line is split into three signals: an output, an output enable and an input. The management clock comes from the system clock through a parameterised divider. Outgoing bits change only when the management clock falls. Incoming bits are sampled when it rises. When a read finishes, the 16 bits returned by the PHY appear in a separate read-data register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word and the read-data register are 0, `mdc` is low, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: `mdc` toggles every `MDC_HALF` system clocks, so one full period is 2*`MDC_HALF` clocks.
- R3: Setting bit 14 of the command word starts a write frame. The frame is 32 ones, then 01, then opcode 01, then PHY address bits [12:8], then register number bits [4:0], then turnaround 10, then the 16 write-data bits. Every field is sent MSB first with `mdio_oe` high. `mdio_o` and `mdio_oe` change only at a falling edge of `mdc`.
- R4: Setting bit 13 of the command word (with bit 14 clear) starts a read frame. The frame is 32 ones, then 01, then opcode 10, then the PHY address, then the register number. `mdio_oe` then drops to 0 for the two turnaround bits and the 16 data bits.
- R5: During the read data phase, `mdio_i` is sampled on each rising edge of `mdc`, MSB first. The 16-bit result is written to `rdat` when the frame completes. `rdat` changes at no other time.
- R6: On the falling edge of `mdc` after the last bit, the controller clears bits 14 and 13 of the command word, leaves bits [15] and [12:0] as written, and drops `mdio_oe` to 0. While neither request bit is set, `mdio_oe` stays 0.
- R7: A command written while bit 14 or bit 13 is set is ignored. The command word keeps its value and the running frame continues unchanged.
- R8: A command with neither request bit set is stored and starts no frame. A command with both request bits set performs a write.
- R9: The write data sent is the write-data register value at the moment the command is accepted. Later writes to that register do not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 16 | Command word value: bit 14 write, bit 13 read, [12:8] PHY, [4:0] register |
| wdat_we | input | 1 | Write strobe for the write-data register |
| wdat_wdata | input | 16 | Value for the write-data register |
| cmd_rd | output | 16 | Current command word; request bits read back as busy |
| rdat | output | 16 | Data returned by the last completed read |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data input from the pad |
| mdio_o | output | 1 | Management data output to the pad |
| mdio_oe | output | 1 | Output enable for the management data pad |

## Verification
The assertions assume the host issues a command only by single-cycle strobes and does not write the write-data register in the same cycle as an accepted command. They also assume that `mdio_i` changes only while the controller has released the line. The stimulus follows these rules: every strobe lasts one cycle, and write-data updates are issued only while idle or in the middle of a frame. A behavioural PHY drives `mdio_i` just after each falling edge of `mdc`, so every rising-edge sample sees a settled bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FIELD_W   = 5;
  localparam int unsigned BIT_WREQ  = 14;
  localparam int unsigned BIT_RREQ  = 13;
  localparam int unsigned PHY_LSB   = 8;
  localparam int unsigned REG_LSB   = 0;
  // bits after the preamble: start, opcode, two fields, turnaround, data
  localparam int unsigned BODY_LEN  = 2 + 2 + 2 * FIELD_W + 2 + DATA_W;
  // body bit index where a read releases the line (turnaround start)
  localparam int unsigned TA_POS    = 2 + 2 + 2 * FIELD_W;
  localparam logic [1:0]  SOF_BITS  = 2'b01;
  localparam logic [1:0]  OPC_READ  = 2'b10;
  localparam logic [1:0]  OPC_WRITE = 2'b01;
  localparam logic [1:0]  TA_DRIVE  = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (MDC_HALF < 2) ? 1 : $clog2(MDC_HALF);
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = (cnt == LAST);
  assign rise_tick = tick & ~mdc;
  assign fall_tick = tick &  mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_read,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] regn,
  input  logic [DATA_W-1:0]  wdat,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               finish,
  output logic [DATA_W-1:0]  cap
);
  localparam int unsigned TOTAL = PRE_LEN + BODY_LEN;
  localparam int unsigned IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] L_PRE   = IW'(PRE_LEN);
  localparam logic [IW-1:0] L_TOTAL = IW'(TOTAL);
  localparam logic [IW-1:0] L_REL   = IW'(PRE_LEN + TA_POS);
  localparam logic [IW-1:0] L_SAMP  = IW'(PRE_LEN + TA_POS + 3);

  logic                active;
  logic                rd_q;
  logic [IW-1:0]       idx;
  logic [BODY_LEN-1:0] sh;

  assign finish = active & fall_tick & (idx == L_TOTAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      cap     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      rd_q   <= is_read;
      idx    <= '0;
      cap    <= '0;
      if (is_read)
        sh <= {SOF_BITS, OPC_READ, phy, regn, 2'b11, {DATA_W{1'b1}}};
      else
        sh <= {SOF_BITS, OPC_WRITE, phy, regn, TA_DRIVE, wdat};
    end else if (active) begin
      if (fall_tick) begin
        if (idx == L_TOTAL) begin
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          if (idx < L_PRE) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
          end else begin
            mdio_o  <= sh[BODY_LEN-1];
            sh      <= {sh[BODY_LEN-2:0], 1'b1};
            mdio_oe <= ~(rd_q & (idx >= L_REL));
          end
        end
      end else if (rise_tick && rd_q && idx >= L_SAMP) begin
        cap <= {cap[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              wdat_we,
  input  logic [DATA_W-1:0] wdat_wdata,
  output logic [DATA_W-1:0] cmd_rd,
  output logic [DATA_W-1:0] rdat,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-1:0] cmd_q, wdat_q, rdat_q, cap;
  logic busy, start, finish, rise_tick, fall_tick;

  assign busy  = cmd_q[BIT_WREQ] | cmd_q[BIT_RREQ];
  assign start = cmd_we & ~busy & (cmd_wdata[BIT_WREQ] | cmd_wdata[BIT_RREQ]);

  mdio_clk_div #(.MDC_HALF(MDC_HALF)) div_i (
    .clk(clk), .rst(rst), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) eng_i (
    .clk(clk), .rst(rst), .start(start),
    .is_read(~cmd_wdata[BIT_WREQ]),
    .phy(cmd_wdata[PHY_LSB +: FIELD_W]),
    .regn(cmd_wdata[REG_LSB +: FIELD_W]),
    .wdat(wdat_q), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .finish(finish), .cap(cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (wdat_we)
        wdat_q <= wdat_wdata;
      if (finish) begin
        cmd_q[BIT_WREQ] <= 1'b0;
        cmd_q[BIT_RREQ] <= 1'b0;
        if (!cmd_q[BIT_WREQ])
          rdat_q <= cap;
      end else if (cmd_we && !busy) begin
        cmd_q <= cmd_wdata;
      end
    end
  end

  assign cmd_rd = cmd_q;
  assign rdat   = rdat_q;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_we,
  input logic [15:0] cmd_rd,
  input logic [15:0] rdat,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic busy;
  assign busy = cmd_rd[14] | cmd_rd[13];

  p_pad_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)) |-> $fell(mdc));

  p_idle_released_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  p_clear_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmd_rd[14]) || $fell(cmd_rd[13])) |-> $fell(mdc));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_we) |=> $stable(cmd_rd[12:0]) && $stable(cmd_rd[15]));

  p_rdat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$fell(cmd_rd[13]) |-> $stable(rdat));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_rd(cmd_rd), .rdat(rdat),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int PRE  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0, wdat_we = 1'b0, mdio_i = 1'b1;
  logic [15:0] cmd_wdata = '0, wdat_wdata = '0;
  logic [15:0] cmd_rd, rdat;
  logic mdc, mdio_o, mdio_oe;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_HALF(HALF), .PRE_LEN(PRE)) dut_i (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .wdat_we(wdat_we), .wdat_wdata(wdat_wdata), .cmd_rd(cmd_rd),
    .rdat(rdat), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0]  q[$];        // {value, oe, sample, phy bit}
  int          m_cnt;
  bit          m_mdc, m_o, m_oe, m_samp, m_pbit, m_rd;
  logic [15:0] m_cmd, m_rdat, m_cap, m_wdat, phy_ret;

  function automatic void build(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    logic [13:0] hdr;
    q.delete();
    for (int k = 0; k < PRE; k++) q.push_back(4'b1100);
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    for (int k = 13; k >= 0; k--) q.push_back({hdr[k], 3'b100});
    if (rd) begin
      q.push_back(4'b1000); q.push_back(4'b1000);
      for (int k = 15; k >= 0; k--) q.push_back({3'b101, phy_ret[k]});
    end else begin
      q.push_back(4'b1100); q.push_back(4'b0100);
      for (int k = 15; k >= 0; k--) q.push_back({d[k], 3'b100});
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_mdc = 0; m_o = 1; m_oe = 0; m_samp = 0; m_pbit = 1;
      m_cmd = 0; m_rdat = 0; m_cap = 0; m_rd = 0; m_wdat = 0; q.delete();
    end else begin
      bit tick, fall, rise, busy;
      logic [3:0] it;
      tick = (m_cnt == HALF - 1);
      fall = tick && m_mdc;
      rise = tick && !m_mdc;
      busy = m_cmd[14] || m_cmd[13];
      if (busy) begin
        if (rise && m_samp) m_cap = {m_cap[14:0], mdio_i};
        if (fall) begin
          if (q.size() > 0) begin
            it = q.pop_front();
            m_o = it[3]; m_oe = it[2]; m_samp = it[1]; m_pbit = it[0];
          end else begin
            m_o = 1; m_oe = 0; m_samp = 0; m_pbit = 1;
            if (m_rd) m_rdat = m_cap;
            m_cmd[14] = 0; m_cmd[13] = 0;
          end
        end
      end else if (cmd_we) begin
        m_cmd = cmd_wdata;
        if (cmd_wdata[14] || cmd_wdata[13]) begin
          m_rd = !cmd_wdata[14];
          m_cap = 0;
          build(m_rd, cmd_wdata[12:8], cmd_wdata[4:0], m_wdat);
        end
      end
      if (wdat_we) m_wdat = wdat_wdata;
      if (tick) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt = m_cnt + 1;
    end
  end

  // PHY side, clock-by-clock comparison and bit collector
  logic [1:0] col[$];       // {oe, value} at each mdc rise of a frame
  int rise_at[$];
  bit prev_mdc = 0, seen_fall = 0;

  always @(negedge clk) begin
    mdio_i <= m_pbit;
    if (!rst) begin
      chk(mdc == m_mdc, "R2 mdc", 32'(mdc), 32'(m_mdc));
      chk(mdio_o == m_o && mdio_oe == m_oe, m_rd ? "R4 read pad" : "R3 write pad",
          {30'd0, mdio_oe, mdio_o}, {30'd0, m_oe, m_o});
      chk(cmd_rd == m_cmd, "R6 command word", 32'(cmd_rd), 32'(m_cmd));
      chk(rdat == m_rdat, "R5 read data", 32'(rdat), 32'(m_rdat));
      if (mdc && !prev_mdc) rise_at.push_back(cyc);
      if ((cmd_rd[14] || cmd_rd[13]) && !mdc && prev_mdc) seen_fall = 1;
      if ((cmd_rd[14] || cmd_rd[13]) && seen_fall && mdc && !prev_mdc)
        col.push_back({mdio_oe, mdio_o});
      prev_mdc = mdc;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_cmd(input logic [15:0] v);
    @(negedge clk); cmd_we = 1; cmd_wdata = v;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic set_wdat(input logic [15:0] v);
    @(negedge clk); wdat_we = 1; wdat_wdata = v;
    @(negedge clk); wdat_we = 0;
  endtask
  task automatic idle_wait();
    while (cmd_rd[14] || cmd_rd[13]) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic clr_col();
    col.delete(); seen_fall = 0;
  endtask
  function automatic logic [15:0] col_bits(int first);
    logic [15:0] r = 0;
    for (int k = 0; k < 16; k++) r = {r[14:0], col[first + k][0]};
    return r;
  endfunction
  function automatic logic [13:0] col_hdr();
    logic [13:0] r = 0;
    for (int k = 0; k < 14; k++) r = {r[12:0], col[PRE + k][0]};
    return r;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_rd == 0 && rdat == 0, "R1 registers", {cmd_rd, rdat}, 0);
    chk(!mdio_oe && mdio_o, "R1 pad", {mdio_oe, mdio_o}, 2'b01);

    // R2 period from consecutive rises
    repeat (12) @(negedge clk);
    chk(rise_at.size() >= 2 && rise_at[1] - rise_at[0] == 2 * HALF, "R2 period",
        rise_at.size() >= 2 ? 32'(rise_at[1] - rise_at[0]) : 0, 2 * HALF);

    // R3 write frame
    set_wdat(16'hA5C3); clr_col();
    do_cmd(16'h4000 | (16'd5 << 8) | 16'h11);
    chk(cmd_rd[14] == 1, "R3 busy bit set", 32'(cmd_rd), 32'h4511);
    idle_wait();
    chk(col.size() == PRE + 32, "R3 bit count", col.size(), PRE + 32);
    chk(col_hdr() == {2'b01, 2'b01, 5'd5, 5'h11}, "R3 header", 32'(col_hdr()), {2'b01, 2'b01, 5'd5, 5'h11});
    chk(col_bits(PRE + 16) == 16'hA5C3, "R3 data", 32'(col_bits(PRE + 16)), 32'hA5C3);
    chk(cmd_rd == 16'h0511 && !mdio_oe, "R6 cleared", {mdio_oe, cmd_rd}, 32'h0511);

    // R4/R5 reads with different PHY patterns
    foreach (phy_ret_list[i]) begin
      phy_ret = phy_ret_list[i]; clr_col();
      do_cmd(16'h2000 | (16'h1F << 8) | 16'(i + 2));
      idle_wait();
      chk(col_hdr() == {2'b01, 2'b10, 5'h1F, 5'(i + 2)}, "R4 header", 32'(col_hdr()), {2'b01, 2'b10, 5'h1F, 5'(i + 2)});
      chk(col[PRE + 14][1] == 0 && col[PRE + 31][1] == 0, "R4 released", {col[PRE + 14], col[PRE + 31]}, 0);
      chk(rdat == phy_ret, "R5 result", 32'(rdat), 32'(phy_ret));
      chk(cmd_rd == ((16'h1F << 8) | 16'(i + 2)), "R6 read cleared", 32'(cmd_rd), (16'h1F << 8) | 16'(i + 2));
    end

    // R7 command during a frame, R9 write data changed mid-frame
    set_wdat(16'h0F0F); clr_col();
    do_cmd(16'h4000 | (16'd3 << 8) | 16'd7);
    repeat (30) @(negedge clk);
    do_cmd(16'h2000 | (16'd9 << 8) | 16'd1);
    chk(cmd_rd == 16'h4307, "R7 ignored command", 32'(cmd_rd), 32'h4307);
    set_wdat(16'hFFFF);
    idle_wait();
    chk(col_bits(PRE + 16) == 16'h0F0F, "R9 data captured at start", 32'(col_bits(PRE + 16)), 32'h0F0F);
    chk(rdat == phy_ret, "R7 rdat untouched", 32'(rdat), 32'(phy_ret));

    // R8 no request bits, then both bits
    do_cmd(16'h0123);
    repeat (8 * HALF * 4) @(negedge clk);
    chk(cmd_rd == 16'h0123 && !mdio_oe, "R8 no frame", {mdio_oe, cmd_rd}, 32'h0123);
    set_wdat(16'h8001); clr_col();
    do_cmd(16'h6000 | (16'd2 << 8) | 16'd4);
    idle_wait();
    chk(col_hdr() == {2'b01, 2'b01, 5'd2, 5'd4}, "R8 both bits write", 32'(col_hdr()), {2'b01, 2'b01, 5'd2, 5'd4});
    chk(col_bits(PRE + 16) == 16'h8001, "R8 write data", 32'(col_bits(PRE + 16)), 32'h8001);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  logic [15:0] phy_ret_list [3] = '{16'h1234, 16'hFFFF, 16'h8001};
endmodule